// File: doc/BRIEF.md
# Status-Decoded Bus Command Controller

This block sits next to a processor whose bus cycles are announced on three active-low status lines instead of separate read and write pins. It watches those lines and decodes each new cycle's code into one system command strobe. It also generates the timing controls that surround the strobe: an address latch pulse, a transfer direction level and a data buffer enable.

A bus cycle begins on the clock edge at which the status code moves away from the passive value 3'b111. The controller then steps through four states, T1 to T4. The address latch pulse covers T1. Read, interrupt-acknowledge and early-write strobes cover T2 and T3, and the ordinary write strobes cover T3 only. If the status returns to passive before T4 would normally arrive, the cycle ends at once. A new cycle can start directly from T4. Halt and passive codes never produce a strobe.

Top module: `bcc_bus_cmd`

## Requirements
- R1: While reset is high, and in the first cycle after it, every command strobe is high (inactive), the address latch pulse and the data enable are low, and the direction output is high.
- R2: A clock edge that samples a non-passive status, with passive (3'b111) sampled on the edge before it and the phase idle or T4, starts a cycle. The address latch output is then high for exactly the following clock period (T1).
- R3: Code 3'b000 (interrupt acknowledge) drives `inta_n` low during T2 and T3.
- R4: Code 3'b001 (I/O read) drives `io_rd_n` low during T2 and T3.
- R5: Code 3'b010 (I/O write) drives `adv_io_wr_n` low during T2 and T3, and `io_wr_n` low during T3 only.
- R6: Code 3'b110 (memory write) drives `adv_mem_wr_n` low during T2 and T3, and `mem_wr_n` low during T3 only.
- R7: Codes 3'b100 (instruction fetch) and 3'b101 (memory read) both drive `mem_rd_n` low during T2 and T3.
- R8: Code 3'b011 (halt) still produces the T1 address latch pulse and walks through T2 to T4, but asserts no strobe and no data enable.
- R9: `den` is high exactly when a command strobe is active, and at most one command type is active at a time. `dt_r` is low from T1 to T4 of read, fetch and interrupt-acknowledge cycles, and high at all other times.
- R10: A passive status sampled while the cycle is in T1, T2 or T3 moves it to T4, which releases every strobe in the next clock period.
- R11: A status held non-passive after the cycle ends starts no further cycle until passive has been seen.
- R12: A non-passive code sampled in T4, with passive sampled on the edge before, starts the next cycle at once (T4 followed directly by T1).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| stat_n | input | 3 | Active-low bus status code from the processor |
| mem_rd_n | output | 1 | Memory read command, active low |
| mem_wr_n | output | 1 | Memory write command, active low |
| io_rd_n | output | 1 | I/O read command, active low |
| io_wr_n | output | 1 | I/O write command, active low |
| adv_mem_wr_n | output | 1 | Early memory write command, active low |
| adv_io_wr_n | output | 1 | Early I/O write command, active low |
| inta_n | output | 1 | Interrupt acknowledge, active low |
| ale | output | 1 | Address latch pulse, high in T1 |
| dt_r | output | 1 | Transfer direction: low toward the processor, high away from it |
| den | output | 1 | Data buffer enable, active high |

## Verification
Two of the block's functions can act on the same clock edge. One is the release of a cycle when passive is sampled; the other is the start of the next cycle. The bench drives the next code one clock after passive returns, so T4 of one cycle is followed directly by T1 of the next, and it also cuts write cycles short after T2 so that the release overtakes the late write strobe. A behavioural model with integer phase counters predicts every output in every clock period, and each prediction is compared half a period after the edge.

// File: rtl/bcc_pkg.sv
package bcc_pkg;

    localparam int STAT_W = 3;

    typedef enum logic [2:0] {
        PH_IDLE = 3'd0,
        PH_T1   = 3'd1,
        PH_T2   = 3'd2,
        PH_T3   = 3'd3,
        PH_T4   = 3'd4
    } phase_e;

    localparam logic [STAT_W-1:0] ST_INTA  = 3'b000;
    localparam logic [STAT_W-1:0] ST_IORD  = 3'b001;
    localparam logic [STAT_W-1:0] ST_IOWR  = 3'b010;
    localparam logic [STAT_W-1:0] ST_HALT  = 3'b011;
    localparam logic [STAT_W-1:0] ST_FETCH = 3'b100;
    localparam logic [STAT_W-1:0] ST_MEMRD = 3'b101;
    localparam logic [STAT_W-1:0] ST_MEMWR = 3'b110;
    localparam logic [STAT_W-1:0] ST_PASS  = 3'b111;

    typedef struct packed {
        logic rd_mem;
        logic rd_io;
        logic wr_mem;
        logic wr_io;
        logic intack;
        logic to_cpu;
        logic xfer;
    } cmd_t;

    function automatic cmd_t decode_stat(input logic [STAT_W-1:0] s);
        cmd_t c;
        c = '0;
        case (s)
            ST_INTA:           begin c.intack = 1'b1; c.to_cpu = 1'b1; c.xfer = 1'b1; end
            ST_IORD:           begin c.rd_io  = 1'b1; c.to_cpu = 1'b1; c.xfer = 1'b1; end
            ST_IOWR:           begin c.wr_io  = 1'b1; c.xfer = 1'b1; end
            ST_FETCH, ST_MEMRD: begin c.rd_mem = 1'b1; c.to_cpu = 1'b1; c.xfer = 1'b1; end
            ST_MEMWR:          begin c.wr_mem = 1'b1; c.xfer = 1'b1; end
            default:           c = '0;
        endcase
        return c;
    endfunction

endpackage

// File: rtl/bcc_decode.sv
module bcc_decode
    import bcc_pkg::*;
(
    input  logic [STAT_W-1:0] stat_n,
    output cmd_t              cmd,
    output logic              passive
);
    always_comb begin
        cmd     = decode_stat(stat_n);
        passive = (stat_n == ST_PASS);
    end
endmodule

// File: rtl/bcc_seq.sv
module bcc_seq
    import bcc_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   passive,
    input  cmd_t   cmd_in,
    output phase_e phase,
    output cmd_t   cmd_q
);
    logic prev_pass;
    logic start;

    always_comb begin
        start = prev_pass && !passive && (phase == PH_IDLE || phase == PH_T4);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase     <= PH_IDLE;
            cmd_q     <= '0;
            prev_pass <= 1'b1;
        end else begin
            prev_pass <= passive;
            if (start) begin
                phase <= PH_T1;
                cmd_q <= cmd_in;
            end else begin
                case (phase)
                    PH_T1:   phase <= passive ? PH_T4 : PH_T2;
                    PH_T2:   phase <= passive ? PH_T4 : PH_T3;
                    PH_T3:   phase <= PH_T4;
                    default: phase <= PH_IDLE;
                endcase
            end
        end
    end
endmodule

// File: rtl/bcc_drive.sv
module bcc_drive
    import bcc_pkg::*;
(
    input  phase_e phase,
    input  cmd_t   cmd_q,
    output logic   mem_rd_n,
    output logic   mem_wr_n,
    output logic   io_rd_n,
    output logic   io_wr_n,
    output logic   adv_mem_wr_n,
    output logic   adv_io_wr_n,
    output logic   inta_n,
    output logic   ale,
    output logic   dt_r,
    output logic   den
);
    logic act;
    logic late;

    always_comb begin
        act          = (phase == PH_T2) || (phase == PH_T3);
        late         = (phase == PH_T3);
        ale          = (phase == PH_T1);
        mem_rd_n     = !(act  && cmd_q.rd_mem);
        io_rd_n      = !(act  && cmd_q.rd_io);
        inta_n       = !(act  && cmd_q.intack);
        adv_mem_wr_n = !(act  && cmd_q.wr_mem);
        adv_io_wr_n  = !(act  && cmd_q.wr_io);
        mem_wr_n     = !(late && cmd_q.wr_mem);
        io_wr_n      = !(late && cmd_q.wr_io);
        den          = act && cmd_q.xfer;
        dt_r         = !((phase != PH_IDLE) && cmd_q.to_cpu);
    end
endmodule

// File: rtl/bcc_bus_cmd.sv
module bcc_bus_cmd
    import bcc_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [STAT_W-1:0] stat_n,
    output logic              mem_rd_n,
    output logic              mem_wr_n,
    output logic              io_rd_n,
    output logic              io_wr_n,
    output logic              adv_mem_wr_n,
    output logic              adv_io_wr_n,
    output logic              inta_n,
    output logic              ale,
    output logic              dt_r,
    output logic              den
);
    cmd_t   dec_cmd;
    cmd_t   cyc_cmd;
    logic   passive;
    phase_e phase;

    bcc_decode u_decode (
        .stat_n  (stat_n),
        .cmd     (dec_cmd),
        .passive (passive)
    );

    bcc_seq u_seq (
        .clk     (clk),
        .rst     (rst),
        .passive (passive),
        .cmd_in  (dec_cmd),
        .phase   (phase),
        .cmd_q   (cyc_cmd)
    );

    bcc_drive u_drive (
        .phase        (phase),
        .cmd_q        (cyc_cmd),
        .mem_rd_n     (mem_rd_n),
        .mem_wr_n     (mem_wr_n),
        .io_rd_n      (io_rd_n),
        .io_wr_n      (io_wr_n),
        .adv_mem_wr_n (adv_mem_wr_n),
        .adv_io_wr_n  (adv_io_wr_n),
        .inta_n       (inta_n),
        .ale          (ale),
        .dt_r         (dt_r),
        .den          (den)
    );
endmodule

// File: rtl/bcc_bus_cmd_chk.sv
module bcc_bus_cmd_chk (
    input logic       clk,
    input logic       rst,
    input logic [2:0] stat_n,
    input logic       mem_rd_n,
    input logic       mem_wr_n,
    input logic       io_rd_n,
    input logic       io_wr_n,
    input logic       adv_mem_wr_n,
    input logic       adv_io_wr_n,
    input logic       inta_n,
    input logic       ale,
    input logic       dt_r,
    input logic       den
);
    logic any_cmd;
    assign any_cmd = !mem_rd_n || !io_rd_n || !inta_n || !adv_mem_wr_n || !adv_io_wr_n;

    AST_RESET_IDLE: assert property (@(posedge clk) rst |=>
        (mem_rd_n && mem_wr_n && io_rd_n && io_wr_n && adv_mem_wr_n && adv_io_wr_n && inta_n && !ale && !den && dt_r)); // R1
    AST_ALE_SINGLE: assert property (@(posedge clk) disable iff (rst) ale |=> !ale); // R2
    AST_ALE_FROM_PASSIVE: assert property (@(posedge clk) disable iff (rst)
        $rose(ale) |-> ($past(stat_n) != 3'b111)); // R2
    AST_IOWR_LATE: assert property (@(posedge clk) disable iff (rst) !io_wr_n |-> !adv_io_wr_n); // R5
    AST_IOWR_AFTER_ADV: assert property (@(posedge clk) disable iff (rst) $fell(io_wr_n) |-> $past(!adv_io_wr_n)); // R5
    AST_MEMWR_LATE: assert property (@(posedge clk) disable iff (rst) !mem_wr_n |-> !adv_mem_wr_n); // R6
    AST_MEMWR_AFTER_ADV: assert property (@(posedge clk) disable iff (rst) $fell(mem_wr_n) |-> $past(!adv_mem_wr_n)); // R6
    AST_DEN_MATCH: assert property (@(posedge clk) disable iff (rst) den == any_cmd); // R9
    AST_ONE_FAMILY: assert property (@(posedge clk) disable iff (rst)
        $onehot0({!mem_rd_n, !io_rd_n, !inta_n, !adv_mem_wr_n, !adv_io_wr_n})); // R9
    AST_NO_STROBE_WITH_ALE: assert property (@(posedge clk) disable iff (rst) ale |-> !any_cmd); // R2
endmodule

bind bcc_bus_cmd bcc_bus_cmd_chk u_chk (
    .clk          (clk),
    .rst          (rst),
    .stat_n       (stat_n),
    .mem_rd_n     (mem_rd_n),
    .mem_wr_n     (mem_wr_n),
    .io_rd_n      (io_rd_n),
    .io_wr_n      (io_wr_n),
    .adv_mem_wr_n (adv_mem_wr_n),
    .adv_io_wr_n  (adv_io_wr_n),
    .inta_n       (inta_n),
    .ale          (ale),
    .dt_r         (dt_r),
    .den          (den)
);

// File: tb/bcc_bus_cmd_bench.sv
module bcc_bus_cmd_bench;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [2:0] stat_n = 3'b111;
    logic mem_rd_n, mem_wr_n, io_rd_n, io_wr_n, adv_mem_wr_n, adv_io_wr_n, inta_n, ale, dt_r, den;

    int    checks = 0;
    int    errors = 0;
    string cur_req = "R1";
    bit    done = 1'b0;

    // reference model state
    int mph = 0;
    int mkind = 7;
    bit mprev = 1'b1;

    always #10 clk = ~clk;

    bcc_bus_cmd u_bcc_bus_cmd (
        .clk(clk), .rst(rst), .stat_n(stat_n),
        .mem_rd_n(mem_rd_n), .mem_wr_n(mem_wr_n), .io_rd_n(io_rd_n), .io_wr_n(io_wr_n),
        .adv_mem_wr_n(adv_mem_wr_n), .adv_io_wr_n(adv_io_wr_n), .inta_n(inta_n),
        .ale(ale), .dt_r(dt_r), .den(den)
    );

    always @(posedge clk) begin
        if (rst) begin
            mph = 0; mkind = 7; mprev = 1'b1;
        end else begin
            int s;
            s = int'(stat_n);
            if (mprev && s != 7 && (mph == 0 || mph == 4)) begin
                mph = 1; mkind = s;
            end else if (mph >= 1 && mph <= 3) begin
                mph = (s == 7) ? 4 : mph + 1;
            end else begin
                mph = 0;
            end
            mprev = (s == 7);
        end
    end

    task automatic chk(input string nm, input logic got, input logic exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s %s actual %b expected %b (t=%0t)", cur_req, nm, got, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (!rst && !done) begin
            bit act, late, rdk;
            act  = (mph == 2 || mph == 3);
            late = (mph == 3);
            rdk  = (mkind == 0 || mkind == 1 || mkind == 4 || mkind == 5);
            chk("ale",          ale,          mph == 1);
            chk("inta_n",       inta_n,       !(act && mkind == 0));
            chk("io_rd_n",      io_rd_n,      !(act && mkind == 1));
            chk("adv_io_wr_n",  adv_io_wr_n,  !(act && mkind == 2));
            chk("io_wr_n",      io_wr_n,      !(late && mkind == 2));
            chk("mem_rd_n",     mem_rd_n,     !(act && (mkind == 4 || mkind == 5)));
            chk("adv_mem_wr_n", adv_mem_wr_n, !(act && mkind == 6));
            chk("mem_wr_n",     mem_wr_n,     !(late && mkind == 6));
            chk("den",          den,          act && mkind != 3 && mkind != 7);
            chk("dt_r",         dt_r,         !(mph != 0 && rdk));
        end
    end

    task automatic bus_cycle(input logic [2:0] code, input int hold, input int idle, input string req);
        cur_req = req;
        @(negedge clk);
        stat_n = code;
        repeat (hold) @(negedge clk);
        stat_n = 3'b111;
        repeat (idle - 1) @(negedge clk);
    endtask

    initial begin
        #(20 * 200000);
        checks++; errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: outputs idle while reset is held
        cur_req = "R1";
        chk("mem_rd_n", mem_rd_n, 1'b1); chk("mem_wr_n", mem_wr_n, 1'b1);
        chk("io_rd_n", io_rd_n, 1'b1);   chk("io_wr_n", io_wr_n, 1'b1);
        chk("adv_mem_wr_n", adv_mem_wr_n, 1'b1); chk("adv_io_wr_n", adv_io_wr_n, 1'b1);
        chk("inta_n", inta_n, 1'b1); chk("ale", ale, 1'b0);
        chk("den", den, 1'b0); chk("dt_r", dt_r, 1'b1);
        rst = 1'b0;
        @(negedge clk);
        bus_cycle(3'b100, 3, 3, "R2");
        bus_cycle(3'b000, 3, 3, "R3");
        bus_cycle(3'b001, 3, 3, "R4");
        bus_cycle(3'b010, 3, 3, "R5");
        bus_cycle(3'b110, 3, 3, "R6");
        bus_cycle(3'b100, 3, 2, "R7");
        bus_cycle(3'b101, 3, 2, "R7");
        bus_cycle(3'b011, 3, 3, "R8");
        bus_cycle(3'b011, 6, 3, "R8");
        bus_cycle(3'b001, 3, 2, "R9");
        bus_cycle(3'b110, 3, 2, "R9");
        bus_cycle(3'b000, 3, 2, "R9");
        bus_cycle(3'b110, 2, 3, "R10");
        bus_cycle(3'b010, 2, 3, "R10");
        bus_cycle(3'b001, 1, 3, "R10");
        bus_cycle(3'b101, 8, 3, "R11");
        bus_cycle(3'b010, 6, 3, "R11");
        bus_cycle(3'b110, 3, 1, "R12");
        bus_cycle(3'b001, 3, 1, "R12");
        bus_cycle(3'b010, 3, 1, "R12");
        bus_cycle(3'b000, 2, 1, "R12");
        bus_cycle(3'b100, 3, 4, "R12");
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule